// File: doc/BRIEF.md
# Prescaled General-Purpose Timer with Three Compare Channels

This block is a memory-mapped up-counting timer. A counter, 32 bits wide by default, advances once for every (divisor + 1) ticks of a selected source clock. The divisor is held in a 12-bit register. A single tick-enable input stands in for the peripheral clock. The counter runs in one of two modes. In free-run mode it wraps at its maximum and raises a rollover flag. In restart mode it returns to zero after matching compare channel 1.

Three compare channels raise sticky status flags. Software clears each flag by writing 1 to it. An interrupt-enable mask, gated by the timer enable, drives one level interrupt. Software reaches the block over a plain word-wide register bus. A write takes effect on the strobe edge, and read data appears one edge after the address is presented. The bus carries no stream data, so it has no valid/ready handshake: every write is accepted, and a read is never stalled.

Register index is the byte address shifted right by two. The indices are:
- 0: control
- 1: divisor
- 2: status
- 3: interrupt mask
- 4 to 6: compare 1 to 3
- 7 and 8: capture values, which always read zero here
- 9: the live count, read-only

Top module: `gp_timer`

## Requirements
- R1: After reset, the following reads return 0: control, divisor, status, mask, both capture indices and the count. Each compare register reads as all ones of the counter width. irq is 0.
- R2: Read data for index addr>>2 appears on bus_rdata after the next clock edge and reflects the registers before that edge. Any unmapped index reads 0.
- R3: A control write stores the written value with the bits of mask 0x00007C14 forced to zero. Those bits always read 0.
- R4: The counter advances by one every (divisor + 1) cycles in which per_tick is high, as long as control bit 0 (enable) is 1 and the source field (control bits 8:6) is 001 or 010. Only the low 12 bits of a divisor write are kept.
- R5: With source code 000, 011, 100, 101, 110 or 111, or with enable at 0, the count holds.
- R6: With control bit 9 (free-run) at 1, the count wraps from all ones to 0. Every wrap from all ones sets status bit 5 (rollover).
- R7: With free-run at 0, a step taken while the count equals compare 1 loads 0 instead of count + 1.
- R8: Status bit n-1 (n = 1 to 3) is set in either of two cases. The first is a step that lands the count on compare n. The second is a write to compare n of a value equal to the current count.
- R9: A write to status clears each of bits 5:0 that is written 1 and leaves the rest unchanged. A flag being set in the same cycle wins over the clear.
- R10: The interrupt mask keeps bits 5:0. irq is 1 exactly when (status AND mask) is nonzero and enable is 1.
- R11: A control write that takes enable from 0 to 1 with control bit 1 (restart-on-enable) set in the written value zeroes the count and the divisor phase.
- R12: A control write with bit 15 set returns every register, the count and the divisor phase to the R1 state. No other field of that write is applied.
- R13: Writes to the capture indices and to the count index change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| per_tick | input | 1 | Peripheral source clock enable, one tick per high cycle |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W | Byte address; index is bits ADDR_W-1:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the presented address |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the following on every cycle:
- the counter increments by one in free-run mode;
- the counter returns to zero after a compare-1 step in restart mode;
- the count holds when no step occurs;
- status flags are sticky unless a status write or soft reset occurs;
- the dropped control bits stay zero;
- the divisor phase clears, and the soft reset clears state.

Only the bench scenarios can show the exact divisor spacing under a given tick pattern and the rollover after a full wrap. They also cover compare-write flag setting, the set-over-clear ordering, and the ignored writes to capture and count. A behavioural model compares the read data and interrupt against the design on every clock.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  // register indices (byte address >> 2)
  localparam int IDX_CTRL = 0;
  localparam int IDX_DIV  = 1;
  localparam int IDX_STAT = 2;
  localparam int IDX_MASK = 3;
  localparam int IDX_CMP0 = 4;
  localparam int IDX_CAPA = 7;
  localparam int IDX_CAPB = 8;
  localparam int IDX_CNT  = 9;

  localparam int NCMP     = 3;
  localparam int ST_W     = 6;
  localparam int ROLL_BIT = 5;

  // control bit positions
  localparam int C_EN     = 0;
  localparam int C_RESTRT = 1;
  localparam int C_SRC    = 6;
  localparam int C_FREE   = 9;
  localparam int C_SWR    = 15;

  localparam logic [31:0] CTRL_DROP = 32'h0000_7C14;
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [PRE_W-1:0] div,
  output logic             step
);
  logic [PRE_W-1:0] phase;
  logic             at_end;

  assign at_end = (phase >= div);
  assign step   = run && at_end && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase <= '0;
    else if (clear)  phase <= '0;
    else if (run)    phase <= at_end ? '0 : phase + 1'b1;
  end

  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (phase == '0)); // R11
  AST_STEP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (step && div != '0) |=> (!step || div == '0)); // R4
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             free_run,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] nxt,
  output logic             wrapped
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assign nxt     = (!free_run && cnt == limit) ? '0 : cnt + 1'b1;
  assign wrapped = step && (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= nxt;
  end

  AST_FREE_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (step && free_run && !clear) |=> (cnt == $past(cnt) + 1'b1)); // R6
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !free_run && !clear && cnt == limit) |=> (cnt == '0)); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(cnt)); // R5
endmodule

// File: rtl/gpt_cmp_bank.sv
module gpt_cmp_bank #(
  parameter int CNT_W = 32,
  parameter int NCH   = 3
) (
  input  logic                      step,
  input  logic [CNT_W-1:0]          nxt,
  input  logic [CNT_W-1:0]          cnt,
  input  logic [NCH-1:0][CNT_W-1:0] cmp_val,
  input  logic [NCH-1:0]            wr_sel,
  input  logic [CNT_W-1:0]          wr_val,
  output logic [NCH-1:0]            hit
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hit[i] = (step && nxt == cmp_val[i]) || (wr_sel[i] && wr_val == cnt);
  end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 12,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              per_tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [CNT_W-1:0] CMP_RST = {CNT_W{1'b1}};

  logic [IDX_W-1:0] idx;
  logic [31:0] cr;
  logic [PRE_W-1:0] pr;
  logic [ST_W-1:0] sr, ir, st_set, st_clr;
  logic [NCMP-1:0][CNT_W-1:0] cmp;
  logic [NCMP-1:0] wr_cmp, hit;
  logic [CNT_W-1:0] cnt, nxt;
  logic wr_ctrl, wr_div, wr_stat, wr_mask, swr, restart, clear;
  logic src_on, run, step, wrapped;
  logic [31:0] rd_mux;
  logic unused_bits;

  assign idx         = bus_addr[ADDR_W-1:2];
  assign unused_bits = ^bus_addr[1:0];

  assign wr_ctrl = bus_we && idx == IDX_W'(IDX_CTRL);
  assign wr_div  = bus_we && idx == IDX_W'(IDX_DIV);
  assign wr_stat = bus_we && idx == IDX_W'(IDX_STAT);
  assign wr_mask = bus_we && idx == IDX_W'(IDX_MASK);
  for (genvar i = 0; i < NCMP; i++) begin : g_wsel
    assign wr_cmp[i] = bus_we && idx == IDX_W'(IDX_CMP0 + i);
  end

  assign swr     = wr_ctrl && bus_wdata[C_SWR];
  assign restart = wr_ctrl && !swr && !cr[C_EN] && bus_wdata[C_EN] && bus_wdata[C_RESTRT];
  assign clear   = swr || restart;

  assign src_on = (cr[C_SRC+:3] == 3'd1) || (cr[C_SRC+:3] == 3'd2);
  assign run    = cr[C_EN] && src_on && per_tick;

  gpt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(clear), .run(run), .div(pr), .step(step));

  gpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step(step), .free_run(cr[C_FREE]),
    .limit(cmp[0]), .cnt(cnt), .nxt(nxt), .wrapped(wrapped));

  gpt_cmp_bank #(.CNT_W(CNT_W), .NCH(NCMP)) u_cmp (
    .step(step), .nxt(nxt), .cnt(cnt), .cmp_val(cmp), .wr_sel(wr_cmp),
    .wr_val(bus_wdata[CNT_W-1:0]), .hit(hit));

  always_comb begin
    st_set = '0;
    st_set[NCMP-1:0] = hit;
    st_set[ROLL_BIT] = wrapped;
    st_clr = wr_stat ? bus_wdata[ST_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr <= '0; pr <= '0; sr <= '0; ir <= '0;
      for (int i = 0; i < NCMP; i++) cmp[i] <= CMP_RST;
    end else if (swr) begin
      cr <= '0; pr <= '0; sr <= '0; ir <= '0;
      for (int i = 0; i < NCMP; i++) cmp[i] <= CMP_RST;
    end else begin
      if (wr_ctrl) cr <= bus_wdata & ~CTRL_DROP;
      if (wr_div)  pr <= bus_wdata[PRE_W-1:0];
      if (wr_mask) ir <= bus_wdata[ST_W-1:0];
      for (int i = 0; i < NCMP; i++)
        if (wr_cmp[i]) cmp[i] <= bus_wdata[CNT_W-1:0];
      sr <= (sr & ~st_clr) | st_set;
    end
  end

  assign irq = cr[C_EN] && |(sr & ir);

  always_comb begin
    rd_mux = '0;
    case (int'(idx))
      IDX_CTRL: rd_mux = cr;
      IDX_DIV:  rd_mux = 32'(pr);
      IDX_STAT: rd_mux = 32'(sr);
      IDX_MASK: rd_mux = 32'(ir);
      IDX_CMP0, IDX_CMP0 + 1, IDX_CMP0 + 2: rd_mux = 32'(cmp[int'(idx) - IDX_CMP0]);
      IDX_CAPA, IDX_CAPB: rd_mux = '0;
      IDX_CNT:  rd_mux = 32'(cnt);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_mux;
  end

  AST_CTRL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ((cr & CTRL_DROP) == '0)); // R3
  AST_SR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stat && !swr) |=> (($past(sr) & ~sr) == '0)); // R9
  AST_SWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    swr |=> (cr == '0 && sr == '0 && ir == '0 && pr == '0 && cnt == '0)); // R12
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cr[C_EN]) |-> !irq); // R10
endmodule

// File: tb/sim_gp_timer.sv
module sim_gp_timer;
  localparam int PERIOD = 10;
  localparam int CW = 10;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic clk = 0, rst_n = 0, per_tick = 0, bus_we = 0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  int total = 0, bad = 0;
  bit live = 0;

  gp_timer #(.CNT_W(CW), .PRE_W(12), .ADDR_W(6)) u0 (
    .clk(clk), .rst_n(rst_n), .per_tick(per_tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [31:0] m_cr, m_rd;
  logic [11:0] m_pr, m_pc;
  logic [5:0]  m_sr, m_ir;
  logic [CW-1:0] m_cmp [3];
  logic [CW-1:0] m_cnt;

  function automatic logic [31:0] m_read(int i);
    case (i)
      0: return m_cr;
      1: return 32'(m_pr);
      2: return 32'(m_sr);
      3: return 32'(m_ir);
      4, 5, 6: return 32'(m_cmp[i-4]);
      9: return 32'(m_cnt);
      default: return 0;
    endcase
  endfunction

  task automatic m_reset();
    m_cr = 0; m_pr = 0; m_sr = 0; m_ir = 0; m_cnt = 0; m_pc = 0;
    for (int i = 0; i < 3; i++) m_cmp[i] = CMAX;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reset(); m_rd = 0;
    end else begin
      int ix; bit swr, rst_en, step, run; logic [5:0] setm, clrm; logic [CW-1:0] nx;
      ix = int'(bus_addr[5:2]);
      m_rd = m_read(ix);
      swr = bus_we && ix == 0 && bus_wdata[15];
      rst_en = bus_we && ix == 0 && !swr && !m_cr[0] && bus_wdata[0] && bus_wdata[1];
      run = m_cr[0] && (m_cr[8:6] == 3'd1 || m_cr[8:6] == 3'd2) && per_tick;
      step = 0;
      if (swr || rst_en) m_pc = 0;
      else if (run) begin
        if (m_pc >= m_pr) begin m_pc = 0; step = 1; end
        else m_pc = m_pc + 1;
      end
      setm = 0;
      nx = (!m_cr[9] && m_cnt == m_cmp[0]) ? '0 : m_cnt + 1'b1;
      if (step) begin
        for (int i = 0; i < 3; i++) if (nx == m_cmp[i]) setm[i] = 1;
        if (m_cnt == CMAX) setm[5] = 1;
      end
      for (int i = 0; i < 3; i++)
        if (bus_we && ix == 4 + i && bus_wdata[CW-1:0] == m_cnt) setm[i] = 1;
      clrm = (bus_we && ix == 2) ? bus_wdata[5:0] : 6'd0;
      m_sr = (m_sr & ~clrm) | setm;
      if (bus_we) begin
        case (ix)
          0: m_cr = bus_wdata & ~32'h7C14;
          1: m_pr = bus_wdata[11:0];
          3: m_ir = bus_wdata[5:0];
          4, 5, 6: m_cmp[ix-4] = bus_wdata[CW-1:0];
          default: ;
        endcase
      end
      if (swr) m_reset();
      else if (rst_en) m_cnt = 0;
      else if (step) m_cnt = nx;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (live) begin
      total++;
      if (bus_rdata !== m_rd) begin
        bad++; $display("FAIL R2 model rdata actual=%h expected=%h", bus_rdata, m_rd);
      end
      total++;
      if (irq !== (m_cr[0] && |(m_sr & m_ir))) begin
        bad++; $display("FAIL R10 model irq actual=%b expected=%b", irq, m_cr[0] && |(m_sr & m_ir));
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++; $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int ix, logic [31:0] d);
    bus_we = 1; bus_addr = 6'(ix << 2); bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd(int ix, output logic [31:0] d);
    bus_addr = 6'(ix << 2);
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    #(PERIOD*150000);
    bad++; $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1; live = 1;
    check("R1 irq", 32'(irq), 0);
    for (int i = 0; i < 10; i++) begin
      rd(i, v);
      check("R1 reset read", v, (i >= 4 && i <= 6) ? 32'(CMAX) : 32'h0);
    end
    rd(12, v); check("R2 unmapped", v, 0);

    wr(0, 32'hFFFF_7FFF); rd(0, v); check("R3 ctrl mask", v, 32'hFFFF_03EB);

    wr(1, 5); wr(3, 32'h3F); wr(4, 7);
    wr(0, 32'h0000_8243);
    rd(0, v); check("R12 ctrl", v, 0);
    rd(1, v); check("R12 div", v, 0);
    rd(3, v); check("R12 mask", v, 0);
    rd(4, v); check("R12 cmp1", v, 32'(CMAX));
    rd(1, v); wr(1, 32'hFFFF_F00A); rd(1, v); check("R4 div 12 bits", v, 32'h00A);
    wr(1, 0);

    per_tick = 1;
    wr(0, 32'h243);
    repeat (1100) @(negedge clk);
    rd(2, v); check("R6 rollover flag", v & 32'h20, 32'h20);

    wr(0, 0); wr(1, 3); wr(0, 32'h243);
    rd(9, v); repeat (7) @(negedge clk); rd(9, v2);
    check("R4 divide by 4", v2 - v, 2);

    wr(0, 32'h203);
    rd(9, v); repeat (7) @(negedge clk); rd(9, v2);
    check("R5 src 000 holds", v2, v);
    wr(0, 32'h3C3);
    rd(9, v); repeat (7) @(negedge clk); rd(9, v2);
    check("R5 src 111 holds", v2, v);

    wr(2, 32'h3F); rd(2, v); check("R9 clear all", v, 0);
    rd(9, v);
    wr(5, v); rd(2, v2); check("R8 cmp2 write equal", v2, 32'h2);
    wr(6, v); rd(2, v2); check("R8 cmp3 write equal", v2, 32'h6);
    wr(2, 32'h2); rd(2, v2); check("R9 clear one", v2, 32'h4);

    wr(3, 0); check("R10 masked", 32'(irq), 0);
    wr(3, 32'h4); check("R10 raised", 32'(irq), 1);
    wr(3, 32'h3B); check("R10 other bits", 32'(irq), 0);
    wr(3, 32'h4); wr(0, 32'h1C2); check("R10 disabled", 32'(irq), 0);

    wr(0, 0); wr(2, 32'h3F); wr(1, 0); wr(4, 5);
    wr(0, 32'h43);
    for (int k = 0; k < 12; k++) begin
      rd(9, v); check("R7 restart bound", 32'(v <= 5), 1);
    end
    rd(2, v); check("R7 cmp1 flag", v & 32'h1, 32'h1);

    wr(0, 32'h42); wr(0, 32'h43);
    rd(9, v); check("R11 restart on enable", v, 0);

    wr(0, 32'h40);
    rd(9, v);
    wr(9, 32'h123); wr(7, 32'h55);
    rd(9, v2); check("R13 count write ignored", v2, v);
    rd(7, v2); check("R13 capture write ignored", v2, 0);

    wr(1, 2); wr(0, 32'h283);
    for (int k = 0; k < 60; k++) begin
      per_tick = k[0]; bus_addr = 6'(9 << 2);
      @(negedge clk);
    end
    per_tick = 0;
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule